// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Load Controller

This controller loads a configuration bitstream into a slave FPGA over its byte-wide configuration port. After a start command with a byte count, it pulls the program pin low for a set number of cycles and then releases it. It then waits until the target reports that it is ready: the init pin high and the busy pin low. Next it selects the target and clocks the bytes from an upstream valid/ready stream, one configuration-clock rising edge per byte. When the data phase is over, it releases the select pins and keeps pulsing the configuration clock until the done pin rises.

Each of the three wait phases (target ready, busy after a byte, done) has its own timeout. Every wait phase reloads the timeout. If a timeout expires, the controller releases the pins, gives a one-cycle abort pulse and reports fail. A normal run ends with pass. The pass or fail result stays on the outputs until the next start.

The state machine has these states. IDLE leaves to PROG on start. PROG leaves to READY when the program pulse is over. READY leaves to SETUP when the target is ready, or to ABORT on timeout. SETUP leaves to FETCH, or to END_CS when the count is zero. FETCH leaves to CLK_LO when a byte is accepted. CLK_LO always leaves to CLK_HI. CLK_HI leaves to BSY_LO if busy is checked and high, else to FETCH, or to END_CS after the last byte. BSY_LO and BSY_HI alternate while busy holds, leave to ABORT_CS on timeout, and leave like CLK_HI once busy clears. END_CS leaves to END_WR, and END_WR leaves to DONE_CHK. DONE_CHK leaves to PASS when done is high, to ABORT on timeout, or else to DN_LO. DN_LO leaves to DN_HI, and DN_HI returns to DONE_CHK. ABORT_CS leaves to ABORT, and ABORT and PASS both return to IDLE.

Top module: `cfg_load_master`

## Requirements
- R1: A start in IDLE drives prog_n_o low for exactly PROG_CYCLES cycles while cs_n_o and wr_n_o stay high. No byte is taken before prog_n_o returns high.
- R2: After the program pulse, the controller selects the target only after it has sampled init_n_i high and busy_i low together.
- R3: Every wait phase (READY, BSY_LO/BSY_HI, DONE_CHK/DN_LO/DN_HI) restarts a timeout of (CLK_HZ/1e6)*WAIT_US cycles. On expiry abort_o pulses high for exactly one cycle and fail_o is set. In READY the pulse comes TIMEOUT+1 cycles after prog_n_o rises.
- R4: wr_n_o and cs_n_o are low and cclk_o is high before the first byte is accepted. s_ready_o is high only in that condition.
- R5: Each accepted byte gets exactly one rising edge of cclk_o with data_o stable across it, and each clock low phase lasts HALF_CYCLES cycles.
- R6: With CHECK_BUSY=1, busy_i high at the end of a byte's high phase produces extra cclk_o pulses, with cs_n_o low, until busy_i is low. The run then continues. If busy never clears, the controller releases cs_n_o one cycle before wr_n_o and aborts.
- R7: After the last byte, cs_n_o rises at least one cycle before wr_n_o rises.
- R8: After the data phase, cclk_o pulses with cs_n_o high until done_i is high. The run then ends with pass_o=1.
- R9: busy_o is high from the cycle after start until the result is latched. A start while busy_o is high has no effect on the byte count or on the run.
- R10: A byte count of 0 selects and deselects the target with no data clock edge and goes straight to the done wait.
- R11: pass_o and fail_o are never both high. Both clear on a new start and otherwise keep their value while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a load (taken only in IDLE) |
| len_i | input | LEN_W | Number of bytes to load |
| s_valid_i | input | 1 | Upstream byte valid |
| s_data_i | input | 8 | Upstream byte |
| s_ready_o | output | 1 | Byte accepted when high with s_valid_i |
| init_n_i | input | 1 | Target init pin, high when ready |
| busy_i | input | 1 | Target busy pin, high when not ready |
| done_i | input | 1 | Target done pin |
| prog_n_o | output | 1 | Program pin, active low |
| cs_n_o | output | 1 | Chip select, active low |
| wr_n_o | output | 1 | Write enable, active low |
| cclk_o | output | 1 | Configuration clock, parked high |
| data_o | output | 8 | Configuration data bus |
| busy_o | output | 1 | Load in progress |
| pass_o | output | 1 | Last load passed |
| fail_o | output | 1 | Last load failed |
| abort_o | output | 1 | One-cycle abort pulse |

## Verification
The byte transfer is tried with a stream that is always valid and with one that has a gap every other cycle. Both must give the same bytes and one clock edge per byte, which shows that clocking follows the accepted bytes and not the cycle count. A run where busy_i holds for a few edges after the second byte is compared with a run where busy_i never clears, to separate the busy stretching from the busy timeout. Runs where init never rises, where done needs three extra edges and where done never comes exercise each timeout on its own. A zero-length run and a start issued mid-run show that the byte count alone decides how many data edges are produced.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_PROG,
        S_READY,
        S_SETUP,
        S_FETCH,
        S_CLK_LO,
        S_CLK_HI,
        S_BSY_LO,
        S_BSY_HI,
        S_END_CS,
        S_END_WR,
        S_DONE_CHK,
        S_DN_LO,
        S_DN_HI,
        S_ABORT_CS,
        S_ABORT,
        S_PASS
    } load_state_e;

endpackage

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
    parameter int LIMIT = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/cfg_pace_counter.sv
module cfg_pace_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         last_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_byte_counter.sv
module cfg_byte_counter #(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             dec_i,
    output logic             zero_o
);
    logic [LEN_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= len_i;
        end else if (dec_i && (left_q != '0)) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign zero_o = (left_q == '0);
endmodule

// File: rtl/cfg_load_master.sv
module cfg_load_master
    import cfg_load_pkg::*;
#(
    parameter int CLK_HZ      = 250000000,
    parameter int WAIT_US     = 10000,
    parameter int PROG_CYCLES = 100,
    parameter int HALF_CYCLES = 2,
    parameter int LEN_W       = 24,
    parameter bit CHECK_BUSY  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             s_valid_i,
    input  logic [7:0]       s_data_i,
    output logic             s_ready_o,
    input  logic             init_n_i,
    input  logic             busy_i,
    input  logic             done_i,
    output logic             prog_n_o,
    output logic             cs_n_o,
    output logic             wr_n_o,
    output logic             cclk_o,
    output logic [7:0]       data_o,
    output logic             busy_o,
    output logic             pass_o,
    output logic             fail_o,
    output logic             abort_o
);
    localparam int TIMEOUT_CYC = (CLK_HZ / 1000000) * WAIT_US;
    localparam int PACE_MAX    = (PROG_CYCLES > HALF_CYCLES) ? PROG_CYCLES : HALF_CYCLES;
    localparam int PACE_W      = $clog2(PACE_MAX + 1);

    load_state_e state_q, state_d;

    logic              pace_last;
    logic              pace_load;
    logic [PACE_W-1:0] pace_val;
    logic              tmo;
    logic              tmo_restart;
    logic              cnt_zero;
    logic              cnt_load;
    logic              cnt_dec;
    logic              busy_hold;
    logic              take_byte;
    logic [7:0]        data_q;
    logic              pass_q, fail_q;

    // Busy stretching is present only when the parameter asks for it
    generate
        if (CHECK_BUSY) begin : g_busy_on
            assign busy_hold = busy_i;
        end else begin : g_busy_off
            assign busy_hold = 1'b0;
        end
    endgenerate

    assign take_byte = (state_q == S_FETCH) && s_valid_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start_i) state_d = S_PROG;
            S_PROG:     if (pace_last) state_d = S_READY;
            S_READY: begin
                if (init_n_i && !busy_i) state_d = S_SETUP;
                else if (tmo)            state_d = S_ABORT;
            end
            S_SETUP:    state_d = cnt_zero ? S_END_CS : S_FETCH;
            S_FETCH:    if (s_valid_i) state_d = S_CLK_LO;
            S_CLK_LO:   if (pace_last) state_d = S_CLK_HI;
            S_CLK_HI: begin
                if (pace_last) begin
                    if (busy_hold)     state_d = S_BSY_LO;
                    else if (cnt_zero) state_d = S_END_CS;
                    else               state_d = S_FETCH;
                end
            end
            S_BSY_LO: begin
                if (tmo)            state_d = S_ABORT_CS;
                else if (pace_last) state_d = S_BSY_HI;
            end
            S_BSY_HI: begin
                if (tmo) begin
                    state_d = S_ABORT_CS;
                end else if (pace_last) begin
                    if (busy_hold)     state_d = S_BSY_LO;
                    else if (cnt_zero) state_d = S_END_CS;
                    else               state_d = S_FETCH;
                end
            end
            S_END_CS:   state_d = S_END_WR;
            S_END_WR:   state_d = S_DONE_CHK;
            S_DONE_CHK: begin
                if (done_i)   state_d = S_PASS;
                else if (tmo) state_d = S_ABORT;
                else          state_d = S_DN_LO;
            end
            S_DN_LO: begin
                if (tmo)            state_d = S_ABORT;
                else if (pace_last) state_d = S_DN_HI;
            end
            S_DN_HI: begin
                if (tmo)            state_d = S_ABORT;
                else if (pace_last) state_d = S_DONE_CHK;
            end
            S_ABORT_CS: state_d = S_ABORT;
            S_ABORT:    state_d = S_IDLE;
            S_PASS:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Timed states reload the pace counter on entry
    assign pace_load = (state_d != state_q);
    assign pace_val  = (state_d == S_PROG) ? PACE_W'(PROG_CYCLES - 1)
                                           : PACE_W'(HALF_CYCLES - 1);

    // Each wait phase restarts the timeout once, on entry
    assign tmo_restart = ((state_q == S_PROG)   && (state_d == S_READY))  ||
                         ((state_q == S_CLK_HI) && (state_d == S_BSY_LO)) ||
                         ((state_q == S_END_WR) && (state_d == S_DONE_CHK));

    assign cnt_load = (state_q == S_IDLE) && start_i;
    assign cnt_dec  = take_byte;

    cfg_pace_counter #(.W(PACE_W)) i_pace (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (pace_load),
        .load_val_i (pace_val),
        .last_o     (pace_last)
    );

    cfg_wait_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (tmo_restart),
        .expired_o (tmo)
    );

    cfg_byte_counter #(.LEN_W(LEN_W)) i_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cnt_load),
        .len_i  (len_i),
        .dec_i  (cnt_dec),
        .zero_o (cnt_zero)
    );

    // Data and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            pass_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            if (take_byte) data_q <= s_data_i;
            if (cnt_load) begin
                pass_q <= 1'b0;
                fail_q <= 1'b0;
            end else if (state_q == S_PASS) begin
                pass_q <= 1'b1;
            end else if (state_q == S_ABORT) begin
                fail_q <= 1'b1;
            end
        end
    end

    // Pin and status outputs decoded from the state
    always_comb begin
        prog_n_o  = 1'b1;
        cs_n_o    = 1'b1;
        wr_n_o    = 1'b1;
        cclk_o    = 1'b1;
        s_ready_o = 1'b0;
        abort_o   = 1'b0;
        unique case (state_q)
            S_PROG:     prog_n_o = 1'b0;
            S_SETUP, S_CLK_HI, S_BSY_HI: begin
                cs_n_o = 1'b0;
                wr_n_o = 1'b0;
            end
            S_FETCH: begin
                cs_n_o    = 1'b0;
                wr_n_o    = 1'b0;
                s_ready_o = 1'b1;
            end
            S_CLK_LO, S_BSY_LO: begin
                cs_n_o = 1'b0;
                wr_n_o = 1'b0;
                cclk_o = 1'b0;
            end
            S_END_CS, S_ABORT_CS: wr_n_o = 1'b0;
            S_DN_LO:    cclk_o  = 1'b0;
            S_ABORT:    abort_o = 1'b1;
            default: ;
        endcase
    end

    assign data_o = data_q;
    assign busy_o = (state_q != S_IDLE);
    assign pass_o = pass_q;
    assign fail_o = fail_q;
endmodule

// File: rtl/cfg_load_master_chk.sv
module cfg_load_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       s_ready_o,
    input logic       init_n_i,
    input logic       busy_i,
    input logic       prog_n_o,
    input logic       cs_n_o,
    input logic       wr_n_o,
    input logic       cclk_o,
    input logic [7:0] data_o,
    input logic       pass_o,
    input logic       fail_o,
    input logic       abort_o
);
    a_r1_prog_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> (cs_n_o && wr_n_o));

    a_r2_select_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> ($past(init_n_i) && !$past(busy_i)));

    a_r3_abort_single_fail: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> (!abort_o && fail_o));

    a_r4_ready_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> (!cs_n_o && !wr_n_o && cclk_o && prog_n_o));

    a_r5_data_stable_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_o) |-> $stable(data_o));

    a_r7_cs_before_wr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n_o) |-> $past(cs_n_o));

    a_r11_result_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o));
endmodule

bind cfg_load_master cfg_load_master_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_ready_o (s_ready_o),
    .init_n_i  (init_n_i),
    .busy_i    (busy_i),
    .prog_n_o  (prog_n_o),
    .cs_n_o    (cs_n_o),
    .wr_n_o    (wr_n_o),
    .cclk_o    (cclk_o),
    .data_o    (data_o),
    .pass_o    (pass_o),
    .fail_o    (fail_o),
    .abort_o   (abort_o)
);

// File: tb/test_cfg_load_master.sv
module test_cfg_load_master;
    localparam int LEN_W   = 8;
    localparam int PROG_C  = 4;
    localparam int HALF_C  = 2;
    localparam int TMO     = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [LEN_W-1:0] len_i = '0;
    logic s_valid_i;
    logic [7:0] s_data_i;
    logic s_ready_o;
    logic init_n_i = 1'b0;
    logic busy_i;
    logic done_i;
    logic prog_n_o, cs_n_o, wr_n_o, cclk_o;
    logic [7:0] data_o;
    logic busy_o, pass_o, fail_o, abort_o;

    always #2 clk = ~clk;

    cfg_load_master #(
        .CLK_HZ(1000000), .WAIT_US(TMO), .PROG_CYCLES(PROG_C),
        .HALF_CYCLES(HALF_C), .LEN_W(LEN_W), .CHECK_BUSY(1'b1)
    ) i_cfg_load_master (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_ready_o(s_ready_o),
        .init_n_i(init_n_i), .busy_i(busy_i), .done_i(done_i),
        .prog_n_o(prog_n_o), .cs_n_o(cs_n_o), .wr_n_o(wr_n_o), .cclk_o(cclk_o),
        .data_o(data_o), .busy_o(busy_o), .pass_o(pass_o), .fail_o(fail_o),
        .abort_o(abort_o)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // Source of bytes
    logic [7:0] src_mem [0:15];
    int  src_idx = 0;
    int  src_len = 0;
    bit  src_gappy = 1'b0;
    bit  src_rst = 1'b0;
    bit  gap_ph = 1'b0;
    assign s_valid_i = (src_idx < src_len) && (!src_gappy || gap_ph);
    assign s_data_i  = src_mem[src_idx[3:0]];

    always @(posedge clk) begin
        gap_ph <= ~gap_ph;
        if (src_rst) src_idx <= 0;
        else if (s_valid_i && s_ready_o) src_idx <= src_idx + 1;
    end

    // Target model and observer
    int done_need = 0;
    int busy_at = 0;
    int busy_len = 0;
    bit mon_clr = 1'b0;
    int cyc = 0;
    int data_rises = 0, done_rises = 0, lo_run = 0;
    int lo_min = 1000, lo_max = 0, prog_lo = 0, order_bad = 0;
    int abort_cnt = 0, early_sel = 0, prog_rise_cyc = 0, abort_cyc = 0;
    int busy_left = 0;
    logic [7:0] cap [0:15];
    logic prev_cclk = 1'b1, prev_cs_n = 1'b1, prev_prog_n = 1'b1;

    assign busy_i = (busy_left != 0);
    assign done_i = (done_rises >= done_need);

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mon_clr) begin
            data_rises <= 0; done_rises <= 0; lo_run <= 0; lo_min <= 1000;
            lo_max <= 0; prog_lo <= 0; order_bad <= 0; abort_cnt <= 0;
            early_sel <= 0; busy_left <= 0; prog_rise_cyc <= 0; abort_cyc <= 0;
        end else begin
            if (!prog_n_o) prog_lo <= prog_lo + 1;
            if (prog_n_o && !prev_prog_n) prog_rise_cyc <= cyc;
            if (abort_o) begin
                abort_cnt <= abort_cnt + 1;
                abort_cyc <= cyc;
            end
            if (!cs_n_o && !init_n_i) early_sel <= early_sel + 1;
            if (wr_n_o && !prev_wr_n_s && !prev_cs_n) order_bad <= order_bad + 1;
            if (!cclk_o) lo_run <= lo_run + 1;
            if (cclk_o && !prev_cclk) begin
                lo_run <= 0;
                if (!cs_n_o) begin
                    data_rises <= data_rises + 1;
                    if (data_rises < 16) cap[data_rises] <= data_o;
                    if (lo_run < lo_min) lo_min <= lo_run;
                    if (lo_run > lo_max) lo_max <= lo_run;
                    if (busy_left != 0) busy_left <= busy_left - 1;
                    else if (data_rises + 1 == busy_at) busy_left <= busy_len;
                end else begin
                    done_rises <= done_rises + 1;
                end
            end
        end
        prev_cclk   <= cclk_o;
        prev_cs_n   <= cs_n_o;
        prev_prog_n <= prog_n_o;
        prev_wr_n_s <= wr_n_o;
    end
    logic prev_wr_n_s = 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    task automatic pulse_start(input int len);
        @(negedge clk);
        len_i = LEN_W'(len);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // One complete load attempt
    task automatic run_load(input int len, input bit gappy, input int dn_need,
                            input bit init_ok, input int b_at, input int b_len,
                            input bit extra_start);
        @(negedge clk);
        src_rst = 1'b1; src_len = len; src_gappy = gappy;
        done_need = dn_need; busy_at = b_at; busy_len = b_len;
        init_n_i = 1'b0;
        @(negedge clk);
        src_rst = 1'b0;
        @(posedge clk); mon_clr = 1'b1;
        @(posedge clk); mon_clr = 1'b0;
        pulse_start(len);
        for (int k = 0; k < 50 && !prog_n_o; k++) @(negedge clk);
        repeat (5) @(negedge clk);
        if (init_ok) init_n_i = 1'b1;
        if (extra_start) begin
            repeat (6) @(negedge clk);
            pulse_start(9);
            src_len = 9;
        end
        for (int k = 0; k < 3000 && busy_o; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(prog_n_o == 1'b1, "R1 reset prog_n", prog_n_o, 1);
        chk(cs_n_o == 1'b1, "R7 reset cs_n", cs_n_o, 1);
        chk(wr_n_o == 1'b1, "R7 reset wr_n", wr_n_o, 1);
        chk(s_ready_o == 1'b0, "R4 reset ready", s_ready_o, 0);
        chk(busy_o == 1'b0, "R9 reset busy", busy_o, 0);
        chk(pass_o == 1'b0 && fail_o == 1'b0, "R11 reset result", pass_o + fail_o, 0);
        chk(abort_o == 1'b0, "R3 reset abort", abort_o, 0);
    endtask

    task automatic check_bytes(input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) if (cap[i] !== src_mem[i]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic t_normal(input bit gappy);
        run_load(5, gappy, 3, 1'b1, 0, 0, 1'b0);
        chk(pass_o && !fail_o, "R8 pass", pass_o, 1);
        chk(data_rises == 5, "R5 one edge per byte", data_rises, 5);
        check_bytes(5, "R5 byte values");
        chk(lo_min == HALF_C && lo_max == HALF_C, "R5 low half period", lo_max, HALF_C);
        chk(prog_lo == PROG_C, "R1 program pulse width", prog_lo, PROG_C);
        chk(early_sel == 0, "R2 select before ready", early_sel, 0);
        chk(order_bad == 0, "R7 cs before wr", order_bad, 0);
        chk(done_rises == 3, "R8 done clock count", done_rises, 3);
        chk(abort_cnt == 0, "R3 no abort", abort_cnt, 0);
        chk(src_idx == 5, "R4 bytes accepted", src_idx, 5);
    endtask

    task automatic t_ignored_start();
        run_load(5, 1'b0, 1, 1'b1, 0, 0, 1'b1);
        chk(data_rises == 5, "R9 start ignored while busy", data_rises, 5);
        chk(pass_o == 1'b1, "R9 run completes", pass_o, 1);
        repeat (5) @(negedge clk);
        chk(pass_o == 1'b1 && !fail_o, "R11 result held", pass_o, 1);
    endtask

    task automatic t_ready_timeout();
        run_load(4, 1'b0, 0, 1'b0, 0, 0, 1'b0);
        chk(fail_o && !pass_o, "R3 ready timeout fail", fail_o, 1);
        chk(abort_cnt == 1, "R3 single abort pulse", abort_cnt, 1);
        chk(abort_cyc - prog_rise_cyc >= TMO && abort_cyc - prog_rise_cyc <= TMO + 2,
            "R3 timeout delay", abort_cyc - prog_rise_cyc, TMO + 1);
        chk(data_rises == 0 && src_idx == 0, "R2 no data without ready", data_rises, 0);
    endtask

    task automatic t_busy_stretch();
        run_load(5, 1'b0, 2, 1'b1, 2, 3, 1'b0);
        chk(pass_o == 1'b1, "R6 pass after busy", pass_o, 1);
        chk(data_rises == 8, "R6 extra busy edges", data_rises, 8);
        chk(src_idx == 5, "R6 byte count unchanged", src_idx, 5);
    endtask

    task automatic t_busy_timeout();
        run_load(5, 1'b0, 0, 1'b1, 2, 100000, 1'b0);
        chk(fail_o && !pass_o, "R6 busy timeout fail", fail_o, 1);
        chk(abort_cnt == 1, "R6 abort pulse", abort_cnt, 1);
        chk(order_bad == 0, "R6 cs released before wr", order_bad, 0);
    endtask

    task automatic t_done_timeout();
        run_load(3, 1'b0, 100000, 1'b1, 0, 0, 1'b0);
        chk(fail_o && !pass_o, "R3 done timeout fail", fail_o, 1);
        chk(data_rises == 3, "R3 data sent before done wait", data_rises, 3);
        chk(done_rises > 10, "R8 done clocks issued", done_rises, 11);
        chk(abort_cnt == 1, "R3 done abort pulse", abort_cnt, 1);
    endtask

    task automatic t_zero_len();
        run_load(0, 1'b0, 0, 1'b1, 0, 0, 1'b0);
        chk(pass_o == 1'b1, "R10 zero length pass", pass_o, 1);
        chk(data_rises == 0, "R10 no data edges", data_rises, 0);
        chk(done_rises == 0, "R10 no done clocks", done_rises, 0);
    endtask

    task automatic t_busy_flag();
        @(negedge clk);
        src_rst = 1'b1; src_len = 2; done_need = 0; init_n_i = 1'b1;
        @(negedge clk);
        src_rst = 1'b0;
        pulse_start(2);
        chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
        chk(!pass_o && !fail_o, "R11 result cleared on start", pass_o + fail_o, 0);
        for (int k = 0; k < 3000 && busy_o; k++) @(negedge clk);
        chk(pass_o == 1'b1, "R9 result at busy drop", pass_o, 1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) src_mem[i] = 8'(8'h3C ^ (i * 37));
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_normal(1'b0);
        t_normal(1'b1);
        t_ignored_start();
        t_ready_timeout();
        t_busy_stretch();
        t_busy_timeout();
        t_done_timeout();
        t_zero_len();
        t_busy_flag();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule